// File: doc/BRIEF.md
# Operand-Swapped Integer ALU

This block is the arithmetic and logic unit of a 32-bit integer datapath. It has no clock and no state. A 4-bit operation code selects one of thirteen functions of the two operands, and the result appears on a single 32-bit output. The functions are: add, subtract, four bitwise operations, two kinds of set-less-than, three shifts, placing a half-word in the upper half, and a forced zero.

The operands must arrive already extended. Sign or zero extension of immediates is done upstream. Wrap-around arithmetic raises no flag.

The shifts are wired the opposite way round from the arithmetic operations. The word being shifted comes from operand B, and the distance comes from the low five bits of operand A. Instructions that do not use the ALU, such as branches and jumps, issue the zero code, so the output stays at zero.

Top module: `opswap_alu`

## Requirements
- R1: Code 4'd1 gives (A + B) mod 2^32, with no overflow indication; load and store address generation uses this same code.
- R2: Code 4'd2 gives (A - B) mod 2^32; for example 0xdbfa08fd minus 0x318c32a8 gives 0xaa6dd655.
- R3: Code 4'd3 gives A AND B, code 4'd4 gives A OR B, and code 4'd5 gives A XOR B, all bit by bit.
- R4: Code 4'd6 gives the bitwise inverse of (A OR B).
- R5: Code 4'd7 gives 32'd1 when A is less than B as two's-complement numbers, and 32'd0 otherwise.
- R6: Code 4'd8 gives 32'd1 when A is less than B as unsigned numbers, and 32'd0 otherwise.
- R7: Code 4'd9 shifts B left by A[4:0], filling with zeros; A[31:5] has no effect on the result.
- R8: Code 4'd10 shifts B right by A[4:0], filling with zeros.
- R9: Code 4'd11 shifts B right by A[4:0] and fills with copies of B[31]; for example an amount word of 0x92153525 applied to 0xb1f05664 gives 0xfd8f82b3.
- R10: Code 4'd12 gives {B[15:0], 16'h0000}; A and B[31:16] have no effect on the result.
- R11: Code 4'd0 gives 32'd0 for every pair of operands.
- R12: The unused codes 4'd13, 4'd14 and 4'd15 give 32'd0.
- R13: The output depends only on the present inputs; the same inputs give the same result no matter what was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A; also the source of the shift distance in its low five bits |
| b_i | input | 32 | Operand B; also the word that the shifts move |
| y_o | output | 32 | Result |

## Verification
Each code is driven with two kinds of operand. The first kind are fixed corner words: zero, all ones, the sign bit alone, the largest positive value, and equal operand pairs. The second kind are pseudo-random words. The corner words separate the signed comparison from the unsigned one, and they expose carries that cross the whole word in add and subtract.

Every shift distance from 0 to 31 is swept, with shift words that have a clear sign bit and words that have a set sign bit. Junk is placed in A[31:5] during the sweep. This separates zero fill from sign fill, and it catches a shift that takes its operands the wrong way round. The upper-half code and the zero codes are driven with varied operands, so that a leak from A or from B[31:16] shows up. Earlier vectors are then applied again, so that any hidden state shows up as a different result.

// File: rtl/opswap_alu_pkg.sv
package opswap_alu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ZERO = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_NOR  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_SLL  = 4'd9,
    OP_SRL  = 4'd10,
    OP_SRA  = 4'd11,
    OP_LUI  = 4'd12,
    OP_RSV0 = 4'd13,
    OP_RSV1 = 4'd14,
    OP_RSV2 = 4'd15
  } alu_op_e;

endpackage

// File: rtl/opswap_alu_addsub.sv
module opswap_alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff = b_i ^ {WIDTH{sub_i}};
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  end

  assign sum_o   = full[WIDTH-1:0];
  assign carry_o = full[WIDTH];

  always_comb begin
    if (sub_i) begin
      // R2
      sub_undo_chk: assert (sum_o + b_i == a_i)
        else $error("difference plus subtrahend does not restore minuend");
    end else begin
      // R1
      add_undo_chk: assert (sum_o - b_i == a_i)
        else $error("sum minus addend does not restore augend");
    end
  end

endmodule

// File: rtl/opswap_alu_shift.sv
module opswap_alu_shift #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [SHW-1:0]   amt_i,
  output logic [WIDTH-1:0] left_o,
  output logic [WIDTH-1:0] rlog_o,
  output logic [WIDTH-1:0] rari_o
);

  logic [WIDTH-1:0] l_stg [SHW+1];
  logic [WIDTH-1:0] r_stg [SHW+1];
  logic [WIDTH-1:0] s_stg [SHW+1];

  assign l_stg[0] = val_i;
  assign r_stg[0] = val_i;
  assign s_stg[0] = val_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign l_stg[k+1] = amt_i[k] ? (l_stg[k] << STEP) : l_stg[k];
    assign r_stg[k+1] = amt_i[k] ? (r_stg[k] >> STEP) : r_stg[k];
    assign s_stg[k+1] = amt_i[k] ? WIDTH'($signed(s_stg[k]) >>> STEP) : s_stg[k];
  end

  assign left_o = l_stg[SHW];
  assign rlog_o = r_stg[SHW];
  assign rari_o = s_stg[SHW];

  always_comb begin
    // R9
    sra_pos_chk: assert (val_i[WIDTH-1] || (rari_o == rlog_o))
      else $error("sign fill differs from zero fill on a non-negative word");
    // R9
    sra_neg_chk: assert (!val_i[WIDTH-1] || ((rari_o & rlog_o) == rlog_o))
      else $error("sign fill lost a bit of the zero-fill result");
    // R8
    srl_msb_chk: assert ((amt_i == '0) || !rlog_o[WIDTH-1])
      else $error("logical right shift left a one in the top bit");
    // R7
    sll_lsb_chk: assert ((amt_i == '0) || !left_o[0])
      else $error("left shift left a one in the bottom bit");
  end

endmodule

// File: rtl/opswap_alu_logic.sv
module opswap_alu_logic #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned HALF = WIDTH / 2
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [HALF-1:0]  imm_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] nor_o,
  output logic [WIDTH-1:0] upper_o
);

  always_comb begin
    and_o   = a_i & b_i;
    or_o    = a_i | b_i;
    xor_o   = a_i ^ b_i;
    nor_o   = ~a_i & ~b_i;
    upper_o = {imm_i, {HALF{1'b0}}};
  end

  always_comb begin
    // R4
    nor_disjoint_chk: assert (((nor_o & or_o) == '0) && ((nor_o | or_o) == '1))
      else $error("nor result is not the complement of the or result");
    // R3
    xor_split_chk: assert ((and_o | xor_o) == or_o)
      else $error("and merged with xor does not give or");
  end

endmodule

// File: rtl/opswap_alu.sv
module opswap_alu
  import opswap_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH),
  localparam int unsigned HALF = WIDTH / 2
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);

  alu_op_e          op;
  logic             do_sub;
  logic [WIDTH-1:0] sum;
  logic             carry;
  logic             lt_s;
  logic             lt_u;
  logic [WIDTH-1:0] sh_l, sh_rl, sh_ra;
  logic [WIDTH-1:0] lg_and, lg_or, lg_xor, lg_nor, lg_up;
  logic [WIDTH-1:0] y_nxt;

  assign op = alu_op_e'(op_i);

  always_comb begin
    do_sub = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  end

  opswap_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (do_sub),
    .sum_o   (sum),
    .carry_o (carry)
  );

  always_comb begin
    lt_u = !carry;
    if (a_i[WIDTH-1] != b_i[WIDTH-1]) lt_s = a_i[WIDTH-1];
    else                              lt_s = sum[WIDTH-1];
  end

  opswap_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .val_i  (b_i),
    .amt_i  (a_i[SHW-1:0]),
    .left_o (sh_l),
    .rlog_o (sh_rl),
    .rari_o (sh_ra)
  );

  opswap_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i     (a_i),
    .b_i     (b_i),
    .imm_i   (b_i[HALF-1:0]),
    .and_o   (lg_and),
    .or_o    (lg_or),
    .xor_o   (lg_xor),
    .nor_o   (lg_nor),
    .upper_o (lg_up)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  y_nxt = sum;
      OP_SUB:  y_nxt = sum;
      OP_AND:  y_nxt = lg_and;
      OP_OR:   y_nxt = lg_or;
      OP_XOR:  y_nxt = lg_xor;
      OP_NOR:  y_nxt = lg_nor;
      OP_SLT:  y_nxt = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: y_nxt = {{(WIDTH-1){1'b0}}, lt_u};
      OP_SLL:  y_nxt = sh_l;
      OP_SRL:  y_nxt = sh_rl;
      OP_SRA:  y_nxt = sh_ra;
      OP_LUI:  y_nxt = lg_up;
      default: y_nxt = '0;
    endcase
  end

  assign y_o = y_nxt;

  always_comb begin
    // R11
    zero_op_chk: assert ((op != OP_ZERO) || (y_o == '0))
      else $error("zero code gave a nonzero result");
    // R12
    rsv_op_chk: assert (!(op inside {OP_RSV0, OP_RSV1, OP_RSV2}) || (y_o == '0))
      else $error("unused code gave a nonzero result");
    // R5
    slt_eq_chk: assert (!((op == OP_SLT) && (a_i == b_i)) || (y_o == '0))
      else $error("signed compare of equal operands gave one");
    // R6
    sltu_width_chk: assert ((op != OP_SLTU) || ((y_o >> 1) == '0))
      else $error("unsigned compare set bits above bit 0");
    // R10
    lui_low_chk: assert ((op != OP_LUI) || (y_o[HALF-1:0] == '0))
      else $error("upper-half placement left low bits set");
  end

endmodule

// File: tb/sim_opswap_alu.sv
module sim_opswap_alu;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [31:0] y;

  int n_vec  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;
  logic [31:0] rng = 32'h1357_9bdf;

  opswap_alu u0 (
    .op_i (op),
    .a_i  (a),
    .b_i  (b),
    .y_o  (y)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG && !done) begin
      done = 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion before %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] w);
    case (o)
      4'd1:  return x + w;
      4'd2:  return x - w;
      4'd3:  return x & w;
      4'd4:  return x | w;
      4'd5:  return x ^ w;
      4'd6:  return ~(x | w);
      4'd7:  return ($signed(x) < $signed(w)) ? 32'd1 : 32'd0;
      4'd8:  return (x < w) ? 32'd1 : 32'd0;
      4'd9:  return w << x[4:0];
      4'd10: return w >> x[4:0];
      4'd11: return 32'($signed(w) >>> x[4:0]);
      4'd12: return {w[15:0], 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R11";
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3, 4'd4, 4'd5: return "R3";
      4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      4'd10: return "R8";
      4'd11: return "R9";
      4'd12: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] w,
                       input logic [31:0] exp, input string tag);
    @(posedge clk);
    op = o; a = x; b = w;
    @(negedge clk);
    n_vec = n_vec + 1;
    if (y !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: op=%0d a=%h b=%h actual %h expected %h", tag, o, x, w, y, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [31:0] x, input logic [31:0] w);
    apply(o, x, w, model(o, x, w), req_of(o));
  endtask

  logic [31:0] corners [8];

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'hffff_ffff;
    corners[2] = 32'h8000_0000; corners[3] = 32'h7fff_ffff;
    corners[4] = 32'h0000_0001; corners[5] = 32'h8000_0001;
    corners[6] = 32'hfffe_0000; corners[7] = 32'h0001_ffff;
    op = 4'd0; a = 32'h0; b = 32'h0;

    // R11: idle code with zero operands gives zero
    apply(4'd0, 32'h0, 32'h0, 32'h0, "R11");

    // Fixed examples
    apply(4'd2, 32'hdbfa08fd, 32'h318c32a8, 32'haa6dd655, "R2");
    apply(4'd11, 32'h92153525, 32'hb1f05664, 32'hfd8f82b3, "R9");
    apply(4'd10, 32'h92153525, 32'hb1f05664, 32'h058f82b3, "R8");
    apply(4'd1, 32'hffff_ffff, 32'h0000_0001, 32'h0, "R1");
    apply(4'd7, 32'h8000_0000, 32'h7fff_ffff, 32'd1, "R5");
    apply(4'd8, 32'h8000_0000, 32'h7fff_ffff, 32'd0, "R6");
    apply(4'd12, 32'hdead_beef, 32'h1234_abcd, 32'habcd_0000, "R10");

    // Corner-pair sweep over every code (R1..R6, R10..R12)
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run(4'(o), corners[i], corners[j]);

    // Pseudo-random operands over every code
    for (int o = 0; o < 16; o++)
      for (int k = 0; k < 40; k++) begin
        logic [31:0] ra, rb;
        rng = next_rand(rng); ra = rng;
        rng = next_rand(rng); rb = rng;
        run(4'(o), ra, rb);
      end

    // Shift sweep: every distance, junk in A[31:5] (R7, R8, R9)
    for (int s = 0; s < 32; s++)
      for (int k = 0; k < 4; k++) begin
        logic [31:0] junk, wv;
        rng = next_rand(rng); junk = {rng[31:5], 5'(s)};
        rng = next_rand(rng); wv = (k < 2) ? {1'b0, rng[30:0]} : {1'b1, rng[30:0]};
        run(4'd9, junk, wv);
        run(4'd10, junk, wv);
        run(4'd11, junk, wv);
      end

    // R13: repeat earlier vectors after other traffic
    apply(4'd2, 32'hdbfa08fd, 32'h318c32a8, 32'haa6dd655, "R13");
    apply(4'd11, 32'h92153525, 32'hb1f05664, 32'hfd8f82b3, "R13");
    apply(4'd0, 32'hffff_ffff, 32'hffff_ffff, 32'h0, "R13");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule